// File: doc/BRIEF.md
# Tag-Only Set-Associative Cache Profiler

This block models whether accesses would hit or miss in a set-associative cache. It holds no data at all: each line is only a stored tag and a valid bit. A request is a physical address qualified by a valid strobe. The block takes the address apart and looks up every way of the addressed set in parallel. One cycle later it reports the result: hit or miss, and the way that matched or was filled.

On a miss the block writes the request tag into a way of that set. It picks the lowest-numbered empty way. When the set is full it picks a victim from a free-running shift register. Hits change nothing and no recency is tracked.

Two running counters, one of accepted accesses and one of misses, give the miss rate of a traffic stream. A synchronous reset empties every line and zeroes both counters.

Top module: `tagcache_profiler`

## Requirements
- R1: With the default parameters (64-byte blocks, 32 sets, 8 ways, 32-bit address), address bits [5:0] are the block offset, bits [10:6] select the set, and bits [31:11] form the tag.
- R2: A request accepted in cycle t (req_valid high at a rising edge) gives resp_valid high after that edge. resp_hit is then 1 only when some way of the selected set is valid and holds the request tag.
- R3: On a miss, the tag is written into the lowest-numbered invalid way of the set, and that way number is returned on resp_way. On a hit, resp_way returns the matching way.
- R4: On a miss into a full set, the victim way is bits [2:0] of a 16-bit shift register, taken in the request's cycle. The register resets to 0xACE1. On every clock out of reset it shifts left by one, and its new bit 0 is the XOR of bits 15, 13, 12 and 10.
- R5: A hit changes no stored state: tags, valid bits and the victim choice on later misses are the same as if the hit had not been made.
- R6: A request to the same block as the request in the previous cycle always hits, because the fill takes effect at the same edge as the response.
- R7: access_count increases by exactly 1 for every accepted request and is unchanged in cycles without one.
- R8: miss_count increases by exactly 1 for every miss and is unchanged on hits and idle cycles.
- R9: While rst_n is low at a rising edge, every valid bit, both counters and resp_valid are cleared. After reset, every address misses until it has been filled.
- R10: Addresses that differ only in the block-offset bits select the same line.
- R11: Cycles with req_valid low leave resp_valid low after the edge and change no line and no counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request strobe |
| req_addr | input | ADDR_W | Physical address of the access |
| resp_valid | output | 1 | Result of the previous cycle's request is present |
| resp_hit | output | 1 | 1 = hit, 0 = miss |
| resp_way | output | log2(WAYS) | Way that matched or was filled |
| access_count | output | CNT_W | Accepted requests since reset |
| miss_count | output | CNT_W | Misses since reset |

## Verification
A corrupted tag or valid bit never shows up at the moment it is corrupted. It first shows when that set is looked up again: a wrong resp_hit, a wrong resp_way, or a miss_count step one cycle after the request. The bench keeps a full reference model of every set and of the victim shift register, and checks every response against it. A wrong line therefore shows on the first later access to the same set. A mis-stepped victim register shows on the first fill of a full set. The counters are compared on every response, so a wrong increment is caught in the cycle it happens.

// File: rtl/tcp_pkg.sv
// Shared constants of the tag-only cache profiler.
// Assumes: a 16-bit Fibonacci shift register is wide enough for victim choice.
package tcp_pkg;
    localparam int          LFSR_W    = 16;
    localparam logic [15:0] LFSR_SEED = 16'hACE1;
    // feedback taps: bits 15, 13, 12, 10
    localparam logic [15:0] LFSR_TAPS = 16'hB400;

    // One shift step of the victim register.
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return {s[LFSR_W-2:0], ^(s & LFSR_TAPS)};
    endfunction
endpackage

// File: rtl/tcp_lfsr.sv
// Free-running victim register: it steps every clock out of reset.
// Assumes: OUT_W <= LFSR_W; the seed is nonzero, so the state never locks up.
module tcp_lfsr
    import tcp_pkg::*;
#(
    parameter int OUT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [OUT_W-1:0] pick
);
    logic [LFSR_W-1:0] state_q;

    // Load the seed in reset, otherwise advance one step.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LFSR_SEED;
        else        state_q <= lfsr_step(state_q);
    end

    assign pick = state_q[OUT_W-1:0];
endmodule

// File: rtl/tcp_tag_store.sv
// Tag and valid storage, one asynchronous read port for a whole set, one write port.
// Assumes: SETS and WAYS are powers of two, both at least 2. Tags are not reset,
// only the valid bits are.
module tcp_tag_store #(
    parameter int SETS  = 32,
    parameter int WAYS  = 8,
    parameter int TAG_W = 21,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SET_W-1:0]           rd_set,
    output logic [WAYS-1:0]            rd_valid,
    output logic [WAYS-1:0][TAG_W-1:0] rd_tags,
    input  logic                       wr_en,
    input  logic [SET_W-1:0]           wr_set,
    input  logic [WAY_W-1:0]           wr_way,
    input  logic [TAG_W-1:0]           wr_tag
);
    logic [WAYS-1:0] valid_q [SETS];

    // Clear every valid bit in reset; mark the written line valid on a fill.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
        end else if (wr_en) begin
            valid_q[wr_set][wr_way] <= 1'b1;
        end
    end

    assign rd_valid = valid_q[rd_set];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tag_mem [SETS];

        // Write the tag into this way when the fill targets it.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_way == WAY_W'(w))) tag_mem[wr_set] <= wr_tag;
        end

        assign rd_tags[w] = tag_mem[rd_set];
    end
endmodule

// File: rtl/tcp_way_select.sv
// Compares all ways of one set with a tag. Reports the matching way and the
// lowest invalid way.
// Assumes: at most one valid way holds a given tag (fills only happen on a miss).
module tcp_way_select #(
    parameter int WAYS  = 8,
    parameter int TAG_W = 21,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]            way_valid,
    input  logic [WAYS-1:0][TAG_W-1:0] way_tags,
    input  logic [TAG_W-1:0]           look_tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           hit_way,
    output logic                       has_free,
    output logic [WAY_W-1:0]           free_way
);
    logic [WAYS-1:0] match;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match[w] = way_valid[w] && (way_tags[w] == look_tag);
    end

    // Priority-encode the match vector and the invalid vector, lowest way wins.
    always_comb begin
        hit_way  = '0;
        free_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i])      hit_way  = WAY_W'(i);
            if (!way_valid[i]) free_way = WAY_W'(i);
        end
    end

    assign hit      = |match;
    assign has_free = ~&way_valid;
endmodule

// File: rtl/tagcache_profiler.sv
// Top of the tag-only cache profiler. It looks up the request address in the
// selected set and fills on a miss. The response is registered one cycle after
// the request; the fill lands at the same edge. Two counters track accesses
// and misses.
// Assumes: BLOCK_BYTES, SETS and WAYS are powers of two, SETS and WAYS >= 2, and
// ADDR_W leaves at least one tag bit.
module tagcache_profiler #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int SETS        = 32,
    parameter int WAYS        = 8,
    parameter int CNT_W       = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    output logic                     resp_valid,
    output logic                     resp_hit,
    output logic [$clog2(WAYS)-1:0]  resp_way,
    output logic [CNT_W-1:0]         access_count,
    output logic [CNT_W-1:0]         miss_count
);
    localparam int OFF_W = $clog2(BLOCK_BYTES);
    localparam int SET_W = $clog2(SETS);
    localparam int WAY_W = $clog2(WAYS);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic [SET_W-1:0]           set_idx;
    logic [TAG_W-1:0]           req_tag;
    logic                       unused_offset;
    logic [WAYS-1:0]            set_valid;
    logic [WAYS-1:0][TAG_W-1:0] set_tags;
    logic                       look_hit;
    logic [WAY_W-1:0]           hit_way;
    logic                       has_free;
    logic [WAY_W-1:0]           free_way;
    logic [WAY_W-1:0]           rand_way;
    logic [WAY_W-1:0]           fill_way;
    logic                       do_fill;

    assign set_idx       = req_addr[OFF_W +: SET_W];
    assign req_tag       = req_addr[ADDR_W-1 -: TAG_W];
    assign unused_offset = ^req_addr[OFF_W-1:0];

    tcp_tag_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_set  (set_idx),
        .rd_valid(set_valid),
        .rd_tags (set_tags),
        .wr_en   (do_fill),
        .wr_set  (set_idx),
        .wr_way  (fill_way),
        .wr_tag  (req_tag)
    );

    tcp_way_select #(.WAYS(WAYS), .TAG_W(TAG_W)) u_select (
        .way_valid(set_valid),
        .way_tags (set_tags),
        .look_tag (req_tag),
        .hit      (look_hit),
        .hit_way  (hit_way),
        .has_free (has_free),
        .free_way (free_way)
    );

    tcp_lfsr #(.OUT_W(WAY_W)) u_lfsr (
        .clk  (clk),
        .rst_n(rst_n),
        .pick (rand_way)
    );

    assign do_fill  = req_valid && !look_hit;
    assign fill_way = has_free ? free_way : rand_way;

    // Register the lookup result one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid <= 1'b0;
            resp_hit   <= 1'b0;
            resp_way   <= '0;
        end else begin
            resp_valid <= req_valid;
            if (req_valid) begin
                resp_hit <= look_hit;
                resp_way <= look_hit ? hit_way : fill_way;
            end
        end
    end

    // Count accepted requests and misses for miss-rate profiling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            access_count <= '0;
            miss_count   <= '0;
        end else if (req_valid) begin
            access_count <= access_count + 1'b1;
            if (!look_hit) miss_count <= miss_count + 1'b1;
        end
    end
endmodule

// File: rtl/tcp_checker.sv
// Port-level properties of the profiler, attached to every instance by bind.
module tcp_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 6,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic [CNT_W-1:0]  access_count,
    input logic [CNT_W-1:0]  miss_count
);
    logic unused_low;
    assign unused_low = ^req_addr[OFF_W-1:0];

    AST_RESP_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> resp_valid); // R2
    AST_NO_RESP_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> !resp_valid); // R11
    AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n) req_valid |=> access_count == $past(access_count) + 1'b1); // R7
    AST_ACC_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !req_valid |=> $stable(access_count)); // R7
    AST_MISS_STEP: assert property (@(posedge clk) disable iff (!rst_n) (resp_valid && !resp_hit) |-> miss_count == $past(miss_count) + 1'b1); // R8
    AST_MISS_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !(resp_valid && !resp_hit) |-> $stable(miss_count)); // R8
    AST_MISS_LE_ACC: assert property (@(posedge clk) disable iff (!rst_n) miss_count <= access_count); // R8
    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && $past(req_valid) && req_addr[ADDR_W-1:OFF_W] == $past(req_addr[ADDR_W-1:OFF_W])) |=> resp_hit); // R6
endmodule

bind tagcache_profiler tcp_checker #(.ADDR_W(ADDR_W), .OFF_W($clog2(BLOCK_BYTES)), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .resp_valid  (resp_valid),
    .resp_hit    (resp_hit),
    .access_count(access_count),
    .miss_count  (miss_count)
);

// File: tb/tb_tagcache_profiler.sv
// Directed bench with a reference model of every set and of the victim register.
module tb_tagcache_profiler;
    localparam int ADDR_W = 32;
    localparam int SETS   = 32;
    localparam int WAYS   = 8;
    localparam int CNT_W  = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic              resp_valid;
    logic              resp_hit;
    logic [2:0]        resp_way;
    logic [CNT_W-1:0]  access_count;
    logic [CNT_W-1:0]  miss_count;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    bit        m_valid [SETS][WAYS];
    bit [20:0] m_tag   [SETS][WAYS];
    bit [15:0] m_lfsr;
    int        exp_acc = 0;
    int        exp_miss = 0;

    always #5 clk = ~clk;

    tagcache_profiler dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
        .access_count(access_count), .miss_count(miss_count)
    );

    // Victim register model, built from R4.
    always @(posedge clk) begin
        if (!rst_n) m_lfsr <= 16'hACE1;
        else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end

    task automatic check(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int tag, input int set, input int off);
        return {21'(tag), 5'(set), 6'(off)};
    endfunction

    task automatic clear_model();
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) m_valid[s][w] = 0;
        exp_acc = 0;
        exp_miss = 0;
    endtask

    // Issue one request at a falling edge, check the response, leave the bench at the next falling edge.
    task automatic access(input string req, input logic [31:0] a);
        int  set = int'(a[10:6]);
        bit [20:0] tg = a[31:11];
        bit  hit = 0;
        int  way = -1;
        for (int w = 0; w < WAYS; w++)
            if (!hit && m_valid[set][w] && m_tag[set][w] == tg) begin hit = 1; way = w; end
        if (!hit) begin
            for (int w = WAYS - 1; w >= 0; w--) if (!m_valid[set][w]) way = w;
            if (way < 0) way = int'(m_lfsr[2:0]);
            m_valid[set][way] = 1;
            m_tag[set][way] = tg;
            exp_miss++;
        end
        exp_acc++;
        req_valid = 1'b1;
        req_addr = a;
        @(posedge clk);
        #1;
        check(req, "resp_valid", resp_valid, 1);
        check(req, "resp_hit", resp_hit, hit);
        check(req, "resp_way", resp_way, way);
        check(req, "access_count", access_count, exp_acc);
        check(req, "miss_count", miss_count, exp_miss);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_valid = 1'b0;
        repeat (3) @(negedge clk);
        clear_model();
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        check("R9", "resp_valid after reset", resp_valid, 0);
        check("R9", "access_count after reset", access_count, 0);
        check("R9", "miss_count after reset", miss_count, 0);
    endtask

    task automatic t_split();
        access("R1", mk(5, 3, 0));      // miss, way 0 of set 3
        access("R10", mk(5, 3, 63));    // same line, other offset: hit way 0
        access("R1", mk(5, 4, 0));      // other set: miss way 0
        access("R1", mk(6, 3, 17));     // other tag, same set: miss way 1
        access("R10", mk(6, 3, 1));     // hit way 1
    endtask

    task automatic t_fill_order();
        for (int i = 0; i < WAYS; i++) access("R3", mk(100 + i, 9, i));
        for (int i = 0; i < WAYS; i++) access("R3", mk(100 + i, 9, 40));
    endtask

    task automatic t_evict();
        access("R4", mk(200, 9, 0));
        @(negedge clk);
        access("R4", mk(201, 9, 0));
        access("R4", mk(200, 9, 8));
    endtask

    task automatic t_hits_keep_state();
        for (int i = 0; i < WAYS; i++) access("R3", mk(300 + i, 12, 0));
        for (int r = 0; r < 3; r++)
            for (int i = 0; i < WAYS; i++) access("R5", mk(300 + i, 12, r));
        access("R5", mk(400, 12, 0));
    endtask

    task automatic t_back_to_back();
        access("R6", mk(500, 20, 0));
        access("R6", mk(500, 20, 33));
        access("R6", mk(501, 21, 2));
        access("R6", mk(501, 21, 62));
    endtask

    task automatic t_idle();
        for (int c = 0; c < 4; c++) begin
            @(posedge clk);
            #1;
            check("R11", "resp_valid idle", resp_valid, 0);
            check("R7", "access_count idle", access_count, exp_acc);
            check("R8", "miss_count idle", miss_count, exp_miss);
        end
        @(negedge clk);
        access("R11", mk(500, 20, 0));  // line filled before the idle gap still hits
    endtask

    task automatic t_reset_again();
        do_reset();
        #1;
        t_reset_state();
        access("R9", mk(500, 20, 0));   // was present, now a miss into way 0
        access("R9", mk(5, 3, 0));
    endtask

    task automatic t_mixed();
        int unsigned seed = 32'h1234_5678;
        for (int n = 0; n < 400; n++) begin
            seed = seed * 32'd1664525 + 32'd1013904223;
            access("R2", mk(int'(seed[27:24]) % 12, int'(seed[19:18]), int'(seed[13:8])));
            if (seed[30]) @(negedge clk);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_reset();
        #1;
        t_reset_state();
        @(negedge clk);
        t_split();
        t_fill_order();
        t_evict();
        t_hits_keep_state();
        t_back_to_back();
        t_idle();
        t_mixed();
        t_reset_again();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule